// File: doc/BRIEF.md
# Code dwell-time linearity corrector

This block post-processes the output of a converter whose input sweeps slowly, so that every output code shows up as a run of identical consecutive samples. It measures each run, keeps a running average of run length, and rewrites the stream so that no ordinary code lasts longer than that average. The samples a run has beyond the average are handed to the next code up, which evens out the widths of wide and narrow codes.

The output is one bit wider than the input. An ordinary code X leaves as 2X. Codes whose low nibble is all zeros or all ones sit where the stage before clips, and their widths are least reliable. Such a run is cut in half in time and leaves as the two finer sub-codes 2X and 2X+1. A run is written out only once its length is known, which is the moment a different code arrives. Finished runs wait in a bounded descriptor queue, and the output carries at most one sample per cycle.

Top module: `dwell_corrector`

## Requirements
- R1: After a synchronous reset, out_valid and out_sat are 0 until a run has completed.
- R2: A run of an ordinary code X whose length L does not exceed the threshold leaves as L samples of code 2X. Ordinary means the low four bits are neither 0000 nor 1111.
- R3: A run of an ordinary code X that is longer than the threshold T leaves as T samples of 2X followed by L-T samples of 2(X+1).
- R4: The threshold for a run is the integer part of the average as it stood before that run completed, with a floor of 1.
- R5: A run of a code whose low four bits are 0000 or 1111 leaves as L-floor(L/2) samples of 2X followed by floor(L/2) samples of 2X+1, whatever the threshold.
- R6: The average is held in fixed point with AVG_FRAC fraction bits and starts at AVG_INIT after reset. The first completed run after reset leaves it unchanged. Each later completed run of length L sets it to avg + ((L·2^AVG_FRAC − avg) >>> AVG_SHIFT), using an arithmetic shift.
- R7: When a run grows past RUN_MAX samples, it is emitted in chunks of RUN_MAX followed by a final remainder. Every chunk is uncorrected: all of its samples are 2X with out_sat=1, and none of the chunks changes the average. Samples that are not saturated leave with out_sat=0.
- R8: Cycles with in_valid=0 neither end a run nor add to it. Completed runs leave in input order and keep their total sample count. The run still in progress stays held until a different code arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_code | input | CODE_W | Converter output code |
| out_valid | output | 1 | Output sample strobe |
| out_code | output | CODE_W+1 | Corrected code at one extra bit of resolution |
| out_sat | output | 1 | Sample belongs to a run that exceeded RUN_MAX and is uncorrected |

## Verification
A wrong run length or a wrong run boundary shows up as a shifted count of 2X against 2(X+1) in the very run that follows. A corrupted average appears as a different split point in every later run of an ordinary code, so runs of equal length at known average values expose it within a few runs. A lost or duplicated queue entry changes the total sample count and the order of codes, and a wrong chunk counter shows up as out_sat on the wrong samples of a long run.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  typedef enum logic [1:0] {
    RK_NORMAL = 2'd0,
    RK_SPLIT  = 2'd1,
    RK_SAT    = 2'd2
  } run_kind_e;
endpackage

// File: rtl/dwc_run_tracker.sv
module dwc_run_tracker #(
  parameter int CODE_W  = 8,
  parameter int RUN_MAX = 32,
  parameter int LEN_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              done_valid,
  output logic [CODE_W-1:0] done_code,
  output logic [LEN_W-1:0]  done_len,
  output logic              done_sat
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(RUN_MAX);

  logic              have_q;
  logic [CODE_W-1:0] cur_code_q;
  logic [LEN_W-1:0]  cur_len_q;
  logic              cur_sat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q     <= 1'b0;
      cur_code_q <= '0;
      cur_len_q  <= '0;
      cur_sat_q  <= 1'b0;
      done_valid <= 1'b0;
      done_code  <= '0;
      done_len   <= '0;
      done_sat   <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      if (in_valid) begin
        if (!have_q) begin
          have_q     <= 1'b1;
          cur_code_q <= in_code;
          cur_len_q  <= LEN_W'(1);
          cur_sat_q  <= 1'b0;
        end else if (in_code == cur_code_q) begin
          if (cur_len_q == LEN_CAP) begin
            // chunk boundary of an over-long run
            done_valid <= 1'b1;
            done_code  <= cur_code_q;
            done_len   <= cur_len_q;
            done_sat   <= 1'b1;
            cur_len_q  <= LEN_W'(1);
            cur_sat_q  <= 1'b1;
          end else begin
            cur_len_q <= cur_len_q + LEN_W'(1);
          end
        end else begin
          done_valid <= 1'b1;
          done_code  <= cur_code_q;
          done_len   <= cur_len_q;
          done_sat   <= cur_sat_q;
          cur_code_q <= in_code;
          cur_len_q  <= LEN_W'(1);
          cur_sat_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dwc_dwell_avg.sv
module dwc_dwell_avg #(
  parameter int LEN_W     = 6,
  parameter int AVG_FRAC  = 4,
  parameter int AVG_SHIFT = 2,
  parameter int AVG_INIT  = 5,
  parameter int AVG_W     = LEN_W + AVG_FRAC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_valid,
  input  logic [LEN_W-1:0] done_len,
  input  logic             done_sat,
  output logic [AVG_W-1:0] avg_q,
  output logic [LEN_W-1:0] thresh
);
  localparam int EXT_W = AVG_W + 2;
  localparam logic [AVG_W-1:0] AVG_RST = AVG_W'(AVG_INIT * (2 ** AVG_FRAC));

  logic                    warm_q;
  logic signed [EXT_W-1:0] sample_fx;
  logic signed [EXT_W-1:0] avg_ext;
  logic signed [EXT_W-1:0] diff;
  logic signed [EXT_W-1:0] step;
  logic signed [EXT_W-1:0] sum;
  logic [LEN_W-1:0]        int_part;

  always_comb begin
    sample_fx = $signed({2'b00, done_len, {AVG_FRAC{1'b0}}});
    avg_ext   = $signed({2'b00, avg_q});
    diff      = sample_fx - avg_ext;
    step      = diff >>> AVG_SHIFT;
    sum       = avg_ext + step;
    int_part  = avg_q[AVG_W-1:AVG_FRAC];
    thresh    = (int_part == '0) ? LEN_W'(1) : int_part;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_q  <= AVG_RST;
      warm_q <= 1'b0;
    end else if (done_valid && !done_sat) begin
      warm_q <= 1'b1;
      if (warm_q) avg_q <= sum[AVG_W-1:0];
    end
  end
endmodule

// File: rtl/dwc_run_queue.sv
module dwc_run_queue #(
  parameter int DW    = 16,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_q;
  logic [AW:0]   rd_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
    end
  end

  assign dout  = mem[rd_q[AW-1:0]];
  assign empty = (wr_q == rd_q);
  assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
endmodule

// File: rtl/dwc_emitter.sv
module dwc_emitter
  import dwc_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  run_kind_e         head_kind,
  input  logic [CODE_W-1:0] head_code,
  input  logic [LEN_W-1:0]  head_len,
  input  logic [LEN_W-1:0]  head_keep,
  output logic              pop,
  output logic              out_valid,
  output logic [CODE_W:0]   out_code,
  output logic              out_sat
);
  logic              busy_q;
  run_kind_e         kind_q;
  logic [CODE_W-1:0] code_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  keep_q;
  logic [LEN_W-1:0]  idx_q;

  run_kind_e         a_kind;
  logic [CODE_W-1:0] a_code;
  logic [LEN_W-1:0]  a_len;
  logic [LEN_W-1:0]  a_keep;
  logic [LEN_W-1:0]  a_idx;
  logic              fire;
  logic              last;
  logic              in_base;
  logic [CODE_W:0]   nxt_code;

  always_comb begin
    a_kind  = busy_q ? kind_q : head_kind;
    a_code  = busy_q ? code_q : head_code;
    a_len   = busy_q ? len_q  : head_len;
    a_keep  = busy_q ? keep_q : head_keep;
    a_idx   = busy_q ? idx_q  : '0;
    fire    = busy_q || !q_empty;
    pop     = !busy_q && !q_empty;
    last    = (a_idx == a_len - LEN_W'(1));
    in_base = (a_idx < a_keep);
    case (a_kind)
      RK_SPLIT: nxt_code = in_base ? {a_code, 1'b0} : {a_code, 1'b1};
      RK_SAT:   nxt_code = {a_code, 1'b0};
      default:  nxt_code = in_base ? {a_code, 1'b0} : {a_code + CODE_W'(1), 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      kind_q    <= RK_NORMAL;
      code_q    <= '0;
      len_q     <= '0;
      keep_q    <= '0;
      idx_q     <= '0;
      out_valid <= 1'b0;
      out_code  <= '0;
      out_sat   <= 1'b0;
    end else begin
      out_valid <= fire;
      out_code  <= fire ? nxt_code : '0;
      out_sat   <= fire && (a_kind == RK_SAT);
      if (fire) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          busy_q <= 1'b1;
          idx_q  <= a_idx + LEN_W'(1);
          if (!busy_q) begin
            kind_q <= head_kind;
            code_q <= head_code;
            len_q  <= head_len;
            keep_q <= head_keep;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dwell_corrector.sv
module dwell_corrector
  import dwc_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int RUN_MAX   = 32,
  parameter int QDEPTH    = 64,
  parameter int AVG_INIT  = 5,
  parameter int AVG_FRAC  = 4,
  parameter int AVG_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [CODE_W:0]   out_code,
  output logic              out_sat
);
  localparam int LEN_W = $clog2(RUN_MAX + 1);
  localparam int AVG_W = LEN_W + AVG_FRAC;
  localparam int DW    = 2 + CODE_W + 2 * LEN_W;

  logic              done_valid;
  logic [CODE_W-1:0] done_code;
  logic [LEN_W-1:0]  done_len;
  logic              done_sat;
  logic [AVG_W-1:0]  avg_q;
  logic [LEN_W-1:0]  thresh;

  run_kind_e         d_kind;
  logic [LEN_W-1:0]  d_keep;
  logic              flagged;
  logic              q_push;
  logic              q_pop;
  logic              q_empty;
  logic              q_full;
  logic [DW-1:0]     q_din;
  logic [DW-1:0]     q_dout;

  dwc_run_tracker #(.CODE_W(CODE_W), .RUN_MAX(RUN_MAX), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .done_valid(done_valid), .done_code(done_code),
    .done_len(done_len), .done_sat(done_sat)
  );

  dwc_dwell_avg #(
    .LEN_W(LEN_W), .AVG_FRAC(AVG_FRAC), .AVG_SHIFT(AVG_SHIFT),
    .AVG_INIT(AVG_INIT), .AVG_W(AVG_W)
  ) u_avg (
    .clk(clk), .rst(rst), .done_valid(done_valid), .done_len(done_len),
    .done_sat(done_sat), .avg_q(avg_q), .thresh(thresh)
  );

  always_comb begin
    flagged = (done_code[3:0] == 4'h0) || (done_code[3:0] == 4'hF);
    if (done_sat) begin
      d_kind = RK_SAT;
      d_keep = done_len;
    end else if (flagged) begin
      d_kind = RK_SPLIT;
      d_keep = done_len - (done_len >> 1);
    end else begin
      d_kind = RK_NORMAL;
      d_keep = (done_len < thresh) ? done_len : thresh;
    end
    q_push = done_valid;
    q_din  = {d_kind, done_code, done_len, d_keep};
  end

  dwc_run_queue #(.DW(DW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .din(q_din), .pop(q_pop),
    .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  dwc_emitter #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_emit (
    .clk(clk), .rst(rst), .q_empty(q_empty),
    .head_kind(run_kind_e'(q_dout[DW-1 -: 2])),
    .head_code(q_dout[2*LEN_W +: CODE_W]),
    .head_len(q_dout[LEN_W +: LEN_W]),
    .head_keep(q_dout[0 +: LEN_W]),
    .pop(q_pop), .out_valid(out_valid), .out_code(out_code), .out_sat(out_sat)
  );
endmodule

// File: rtl/dwc_checker.sv
module dwc_checker #(
  parameter int CODE_W = 8,
  parameter int AVG_W  = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic [CODE_W:0]  out_code,
  input logic             out_sat,
  input logic             q_push,
  input logic             q_full,
  input logic             done_valid,
  input logic [AVG_W-1:0] avg_q
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_sat));

  a_r7_sat_has_valid: assert property (@(posedge clk) disable iff (rst)
    out_sat |-> out_valid);

  a_r7_sat_is_even: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sat) |-> !out_code[0]);

  a_r5_odd_only_clipped: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_code[0]) |-> ((out_code[4:1] == 4'h0) || (out_code[4:1] == 4'hF)));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    q_push |-> !q_full);

  a_r6_avg_moves_on_done: assert property (@(posedge clk) disable iff (rst)
    !done_valid |=> $stable(avg_q));
endmodule

bind dwell_corrector dwc_checker #(.CODE_W(CODE_W), .AVG_W(AVG_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_code(out_code),
  .out_sat(out_sat), .q_push(q_push), .q_full(q_full),
  .done_valid(done_valid), .avg_q(avg_q)
);

// File: tb/sim_dwell_corrector.sv
`timescale 1ns/1ps
module sim_dwell_corrector;
  localparam int CODE_W  = 8;
  localparam int RUN_MAX = 32;
  localparam int FRAC    = 4;
  localparam int SHIFT   = 2;
  localparam int INIT    = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [CODE_W-1:0] in_code = '0;
  logic              out_valid;
  logic [CODE_W:0]   out_code;
  logic              out_sat;

  int n_checks = 0;
  int n_fail   = 0;

  int rc [16];
  int rl [16];
  int nr;
  int    exp_code [1024];
  bit    exp_sat  [1024];
  string exp_tag  [1024];
  int    n_exp;
  int    got_code [1024];
  bit    got_sat  [1024];
  int    n_got;
  string tag_override;
  bit    gaps;

  always #2.5 clk = ~clk;

  dwell_corrector #(.CODE_W(CODE_W), .RUN_MAX(RUN_MAX), .AVG_INIT(INIT),
                    .AVG_FRAC(FRAC), .AVG_SHIFT(SHIFT)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_code(out_code), .out_sat(out_sat)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && n_got < 1024) begin
      got_code[n_got] = int'(out_code);
      got_sat[n_got]  = out_sat;
      n_got++;
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push_exp(int code, bit sat, string tag);
    exp_code[n_exp] = code;
    exp_sat[n_exp]  = sat;
    exp_tag[n_exp]  = (tag_override != "") ? tag_override : tag;
    n_exp++;
  endtask

  // expected stream, built from the requirement text
  task automatic build_expect();
    int avg = INIT * (2 ** FRAC);
    bit warm = 0;
    n_exp = 0;
    for (int r = 0; r < nr; r++) begin
      int c = rc[r];
      int rem = rl[r];
      bit sat = 0;
      while (rem > RUN_MAX) begin
        for (int i = 0; i < RUN_MAX; i++) push_exp(2 * c, 1, "R7");
        rem -= RUN_MAX;
        sat = 1;
      end
      if (sat) begin
        for (int i = 0; i < rem; i++) push_exp(2 * c, 1, "R7");
      end else begin
        int t = avg / (2 ** FRAC);
        if (t == 0) t = 1;
        if ((c % 16) == 0 || (c % 16) == 15) begin
          int k = rem - rem / 2;
          for (int i = 0; i < rem; i++) push_exp(i < k ? 2 * c : 2 * c + 1, 0, "R5");
        end else begin
          for (int i = 0; i < rem; i++) push_exp(i < t ? 2 * c : 2 * c + 2, 0, i < t ? "R2" : "R3");
        end
        if (warm) avg = avg + ((rem * (2 ** FRAC) - avg) >>> SHIFT);
        warm = 1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_got = 0;
    @(negedge clk);
    check("R1", int'(out_valid), 0, "out_valid after reset");
    check("R1", int'(out_sat), 0, "out_sat after reset");
  endtask

  task automatic run_case(string name);
    int term;
    do_reset();
    build_expect();
    for (int r = 0; r < nr; r++) begin
      for (int i = 0; i < rl[r]; i++) begin
        in_valid = 1'b1;
        in_code  = CODE_W'(rc[r]);
        @(negedge clk);
        if (gaps) begin
          in_valid = 1'b0;
          in_code  = ~CODE_W'(rc[r]);
          @(negedge clk);
        end
      end
    end
    term = (rc[nr-1] == 8'h77) ? 8'h78 : 8'h77;
    in_valid = 1'b1;
    in_code  = CODE_W'(term);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (200) @(negedge clk);
    check("R8", n_got, n_exp, {name, " sample count"});
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(exp_tag[i], got_code[i], exp_code[i], $sformatf("%s code #%0d", name, i));
      check(exp_tag[i], int'(got_sat[i]), int'(exp_sat[i]), $sformatf("%s sat #%0d", name, i));
    end
  endtask

  task automatic t_short_runs();
    tag_override = "R4"; gaps = 0;
    nr = 3;
    rc[0] = 'h21; rl[0] = 3;
    rc[1] = 'h22; rl[1] = 4;
    rc[2] = 'h23; rl[2] = 5;
    run_case("short_runs");
  endtask

  task automatic t_surplus();
    tag_override = ""; gaps = 0;
    nr = 3;
    rc[0] = 'h41; rl[0] = 7;
    rc[1] = 'h42; rl[1] = 3;
    rc[2] = 'h43; rl[2] = 2;
    run_case("surplus");
  endtask

  task automatic t_clipped();
    tag_override = ""; gaps = 0;
    nr = 5;
    rc[0] = 'h50; rl[0] = 5;
    rc[1] = 'h5F; rl[1] = 4;
    rc[2] = 'h60; rl[2] = 9;
    rc[3] = 'h61; rl[3] = 2;
    rc[4] = 'hFF; rl[4] = 1;
    run_case("clipped");
  endtask

  task automatic t_average();
    tag_override = "R6"; gaps = 0;
    nr = 8;
    rc[0] = 'h11; rl[0] = 2;
    for (int r = 1; r < 8; r++) begin
      rc[r] = 'h11 + r;
      rl[r] = 9;
    end
    run_case("average");
  endtask

  task automatic t_saturate();
    tag_override = ""; gaps = 0;
    nr = 3;
    rc[0] = 'h33; rl[0] = 40;
    rc[1] = 'h34; rl[1] = 7;
    rc[2] = 'h35; rl[2] = RUN_MAX;
    run_case("saturate");
  endtask

  task automatic t_gaps();
    tag_override = "R8"; gaps = 1;
    nr = 3;
    rc[0] = 'h72; rl[0] = 6;
    rc[1] = 'h73; rl[1] = 3;
    rc[2] = 'h74; rl[2] = 8;
    run_case("gaps");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    tag_override = "";
    gaps = 0;
    t_short_runs();
    t_surplus();
    t_clipped();
    t_average();
    t_saturate();
    t_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule